// File: doc/BRIEF.md
# Module and Power-Domain Sleep Controller

This block sequences the run state of a set of on-chip modules grouped into power domains. Software writes a requested state and a local-reset bit into each module's control word; nothing changes in the module until software issues a go command for the module's domain. The controller then runs a transition of fixed length, during which a per-domain busy bit reads 1. When it ends, every module of that domain reports its requested state, and the module clock enable and reset outputs follow that state.

A domain that is off and is asked to come on goes through a two-step handshake. First the controller raises a power request towards an external power switch and holds it until that switch acknowledges. Then it waits for software to confirm power-good in the domain control word. A domain that is already on, or that is being switched off, skips the handshake. Go commands that reach a domain while its transition runs are dropped.

The register bus is a single-cycle write port with read data registered one cycle after the address is presented. Domain 0 is on after reset by default; the other domains start off.

Top module: `psc_ctrl`

## Requirements
- R1: After reset every module reports state 0 with its clock enable low and its reset output high, every control word reads 0, the busy and pending registers read 0, no power request is raised, and domain status reads 1 for domain 0 and 0 for the others.
- R2: The module control word at 0xA00 + 4*m keeps the requested state in bits [1:0] (0 software-reset disable, 1 sync reset, 2 disable, 3 enable), reads 0 in bits [5:2] of the state field whatever was written there, and keeps the active-low local-reset bit in bit 8.
- R3: Writing 1 to bit n of the go register at 0x120 starts a transition of domain n. For a domain that needs no power handshake, bit n of the busy register at 0x128 reads 1 on exactly XFER_CYCLES back-to-back reads after the write. Other domains' busy bits stay 0.
- R4: When a transition ends, bits [5:0] of the module status word at 0x800 + 4*m equal the requested state for every module of that domain. Writing a new request without a go leaves the status and the outputs unchanged.
- R5: Status bit 12 and mod_clk_en are 1 only in state 3. mod_rst is 1 in states 0 and 1 or while local-reset bit 8 is 0, and 0 in states 2 and 3 with bit 8 set. A local-reset write takes effect on the next clock without a go.
- R6: Domain status bits [4:0] at 0x200 + 4*n read 1 when the domain is on and 0 when it is off. A go to an off domain whose control word at 0x300 + 4*n has next-state bit 0 set raises pwr_req[n] and pending bit n at 0x070. pwr_req[n] stays high until pwr_ack[n] is seen.
- R7: After the acknowledge, pending and busy stay set and the domain stays off until software writes 1 to power-good bit 8 of the domain control word. The transition then completes XFER_CYCLES+1 reads after that write, the domain reads on, and the power-good bit reads 0 again.
- R8: A go command for a domain whose transition is running is ignored, and the transition ends at its original time.
- R9: A go to an on domain with next-state bit 0 clear switches the domain off after XFER_CYCLES cycles and raises no power request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| pwr_ack | input | NUM_DOMAINS | External power acknowledge per domain |
| pwr_req | output | NUM_DOMAINS | External power request per domain |
| mod_clk_en | output | NUM_DOMAINS*MOD_PER_DOM | Module clock enable |
| mod_rst | output | NUM_DOMAINS*MOD_PER_DOM | Module reset, active high |

## Verification
The embedded assertions watch, on every cycle, that a module's reported state moves only on the commit of its domain and lands on the request, that the clock enable and reset outputs agree with the state and the local-reset bit, that a power request is held until acknowledged and never raised for an on domain, that a domain flips only as its busy bit drops, and that a repeated go leaves a running count undisturbed. The exact busy length, the wait for software's power-good write, the clearing of that bit, and the register encodings seen through the bus can only be shown by the bench's scenarios, which poll the busy bit and read back the status words.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // Register offsets (byte addresses, one 32-bit word per slot)
  localparam int OFS_PEND  = 'h070;
  localparam int OFS_GO    = 'h120;
  localparam int OFS_BUSY  = 'h128;
  localparam int OFS_DSTAT = 'h200;
  localparam int OFS_DCTL  = 'h300;
  localparam int OFS_MSTAT = 'h800;
  localparam int OFS_MCTL  = 'hA00;

  // Bit positions software relies on
  localparam int BIT_LRST_N = 8;
  localparam int BIT_CLK_ON = 12;
  localparam int BIT_NEXT   = 0;
  localparam int BIT_GOOD   = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    MS_SWRSTDIS = 2'd0,
    MS_SYNCRST  = 2'd1,
    MS_DISABLE  = 2'd2,
    MS_ENABLE   = 2'd3
  } mstate_t;

  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_REQ  = 2'd1,
    DS_GOOD = 2'd2,
    DS_RUN  = 2'd3
  } dfsm_t;

  function automatic addr_t slot_addr(input int base, input int idx);
    return addr_t'(base + 4 * idx);
  endfunction

endpackage

// File: rtl/psc_domain_ctrl.sv
module psc_domain_ctrl
  import psc_pkg::*;
#(
  parameter int XFER_CYCLES = 4,
  parameter bit ON_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic wr_next,
  input  logic wr_good,
  input  logic go,
  input  logic pwr_ack,
  output logic next_on,
  output logic pgood,
  output logic dom_on,
  output logic busy,
  output logic pend,
  output logic pwr_req,
  output logic commit
);

  localparam int CNT_W = $clog2(XFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XFER_CYCLES - 1);

  dfsm_t            st;
  logic [CNT_W-1:0] cnt;

  assign busy   = (st != DS_IDLE);
  assign pend   = (st == DS_REQ) || (st == DS_GOOD);
  assign commit = (st == DS_RUN) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= DS_IDLE;
      cnt     <= '0;
      dom_on  <= ON_AT_RESET;
      next_on <= ON_AT_RESET;
      pgood   <= 1'b0;
      pwr_req <= 1'b0;
    end else begin
      if (ctl_we) begin
        next_on <= wr_next;
        pgood   <= wr_good;
      end
      unique case (st)
        DS_IDLE: begin
          if (go) begin
            if (!dom_on && next_on) begin
              st      <= DS_REQ;
              pwr_req <= 1'b1;
            end else begin
              st  <= DS_RUN;
              cnt <= '0;
            end
          end
        end
        DS_REQ: begin
          if (pwr_ack) begin
            st      <= DS_GOOD;
            pwr_req <= 1'b0;
          end
        end
        DS_GOOD: begin
          if (pgood) begin
            st    <= DS_RUN;
            cnt   <= '0;
            pgood <= 1'b0;
          end
        end
        DS_RUN: begin
          if (cnt == LAST) begin
            st     <= DS_IDLE;
            dom_on <= next_on;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= DS_IDLE;
      endcase
    end
  end

  AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (pwr_req && !pwr_ack) |=> pwr_req); // R6
  AST_NO_REQ_WHEN_ON: assert property (@(posedge clk) disable iff (rst)
    pwr_req |-> !dom_on); // R6
  AST_DOM_FLIPS_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(dom_on) |-> ($past(busy) && !busy)); // R3
  AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st == DS_RUN && cnt != LAST && go) |=> (st == DS_RUN && cnt == $past(cnt) + 1'b1)); // R8

endmodule

// File: rtl/psc_module_slot.sv
module psc_module_slot
  import psc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ctl_we,
  input  mstate_t wr_state,
  input  logic    wr_lrst_n,
  input  logic    commit,
  output mstate_t req_state,
  output mstate_t cur_state,
  output logic    lrst_n,
  output logic    clk_en,
  output logic    mrst
);

  mstate_t nxt_state;
  logic    nxt_lrst_n;

  always_comb begin
    nxt_state  = commit ? req_state : cur_state;
    nxt_lrst_n = ctl_we ? wr_lrst_n : lrst_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_state <= MS_SWRSTDIS;
      cur_state <= MS_SWRSTDIS;
      lrst_n    <= 1'b0;
      clk_en    <= 1'b0;
      mrst      <= 1'b1;
    end else begin
      if (ctl_we) begin
        req_state <= wr_state;
        lrst_n    <= wr_lrst_n;
      end
      cur_state <= nxt_state;
      clk_en    <= (nxt_state == MS_ENABLE);
      mrst      <= !nxt_lrst_n ||
                   (nxt_state == MS_SWRSTDIS) || (nxt_state == MS_SYNCRST);
    end
  end

  AST_STATE_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_state) |-> $past(commit)); // R4
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cur_state == $past(req_state))); // R4
  AST_CLK_ONLY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> (cur_state == MS_ENABLE)); // R5
  AST_RST_IN_RESET_STATES: assert property (@(posedge clk) disable iff (rst)
    (cur_state == MS_SWRSTDIS || cur_state == MS_SYNCRST || !lrst_n) |-> mrst); // R5

endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int NUM_DOMAINS = 2,
  parameter int MOD_PER_DOM = 2,
  parameter int XFER_CYCLES = 4,
  parameter logic [NUM_DOMAINS-1:0] DOM_ON_RESET = 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 bus_we,
  input  logic [11:0]                          bus_addr,
  input  logic [31:0]                          bus_wdata,
  output logic [31:0]                          bus_rdata,
  input  logic [NUM_DOMAINS-1:0]               pwr_ack,
  output logic [NUM_DOMAINS-1:0]               pwr_req,
  output logic [NUM_DOMAINS*MOD_PER_DOM-1:0]   mod_clk_en,
  output logic [NUM_DOMAINS*MOD_PER_DOM-1:0]   mod_rst
);

  localparam int NUM_MODS = NUM_DOMAINS * MOD_PER_DOM;

  logic [NUM_DOMAINS-1:0] d_next, d_good, d_on, d_busy, d_pend, d_commit;
  logic [NUM_DOMAINS-1:0] d_ctl_we, d_go;
  logic [NUM_MODS-1:0]    m_ctl_we, m_lrst_n;
  mstate_t                m_req [NUM_MODS];
  mstate_t                m_cur [NUM_MODS];
  word_t                  rd_nxt;
  logic                   wdata_unused;

  // Bits [5:2] of the module state field and other reserved bits are dropped
  assign wdata_unused = ^bus_wdata;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    assign d_ctl_we[d] = bus_we && (bus_addr == slot_addr(OFS_DCTL, d));
    assign d_go[d]     = bus_we && (bus_addr == addr_t'(OFS_GO)) && bus_wdata[d];

    psc_domain_ctrl #(
      .XFER_CYCLES (XFER_CYCLES),
      .ON_AT_RESET (DOM_ON_RESET[d])
    ) i_dom (
      .clk     (clk),
      .rst     (rst),
      .ctl_we  (d_ctl_we[d]),
      .wr_next (bus_wdata[BIT_NEXT]),
      .wr_good (bus_wdata[BIT_GOOD]),
      .go      (d_go[d]),
      .pwr_ack (pwr_ack[d]),
      .next_on (d_next[d]),
      .pgood   (d_good[d]),
      .dom_on  (d_on[d]),
      .busy    (d_busy[d]),
      .pend    (d_pend[d]),
      .pwr_req (pwr_req[d]),
      .commit  (d_commit[d])
    );
  end

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    localparam int DOM = m / MOD_PER_DOM;
    assign m_ctl_we[m] = bus_we && (bus_addr == slot_addr(OFS_MCTL, m));

    psc_module_slot i_slot (
      .clk       (clk),
      .rst       (rst),
      .ctl_we    (m_ctl_we[m]),
      .wr_state  (mstate_t'(bus_wdata[1:0])),
      .wr_lrst_n (bus_wdata[BIT_LRST_N]),
      .commit    (d_commit[DOM]),
      .req_state (m_req[m]),
      .cur_state (m_cur[m]),
      .lrst_n    (m_lrst_n[m]),
      .clk_en    (mod_clk_en[m]),
      .mrst      (mod_rst[m])
    );
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == addr_t'(OFS_PEND)) rd_nxt[NUM_DOMAINS-1:0] = d_pend;
    if (bus_addr == addr_t'(OFS_BUSY)) rd_nxt[NUM_DOMAINS-1:0] = d_busy;
    for (int i = 0; i < NUM_DOMAINS; i++) begin
      if (bus_addr == slot_addr(OFS_DSTAT, i)) rd_nxt[4:0] = {4'b0, d_on[i]};
      if (bus_addr == slot_addr(OFS_DCTL, i)) begin
        rd_nxt[BIT_NEXT] = d_next[i];
        rd_nxt[BIT_GOOD] = d_good[i];
      end
    end
    for (int i = 0; i < NUM_MODS; i++) begin
      if (bus_addr == slot_addr(OFS_MSTAT, i)) begin
        rd_nxt[5:0]        = {4'b0, m_cur[i]};
        rd_nxt[BIT_CLK_ON] = mod_clk_en[i];
      end
      if (bus_addr == slot_addr(OFS_MCTL, i)) begin
        rd_nxt[5:0]        = {4'b0, m_req[i]};
        rd_nxt[BIT_LRST_N] = m_lrst_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

  AST_REQ_IMPLIES_PEND: assert property (@(posedge clk) disable iff (rst)
    (pwr_req != '0) |-> ((pwr_req & ~d_pend) == '0)); // R6
  AST_PEND_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((d_pend & ~d_busy) == '0)); // R7

endmodule

// File: tb/test_psc_ctrl.sv
module test_psc_ctrl;
  import psc_pkg::*;

  localparam int ND   = 2;
  localparam int MPD  = 2;
  localparam int NM   = ND * MPD;
  localparam int XFER = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_we;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [ND-1:0] pwr_ack;
  logic [ND-1:0] pwr_req;
  logic [NM-1:0] mod_clk_en;
  logic [NM-1:0] mod_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  psc_ctrl #(.NUM_DOMAINS(ND), .MOD_PER_DOM(MPD), .XFER_CYCLES(XFER)) i_psc_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_ack(pwr_ack),
    .pwr_req(pwr_req), .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
  );

  // {module, state[1:0], lrst_n, expected clk_en, expected reset}
  localparam logic [5:0] VEC [6] = '{
    {1'b0, 2'd3, 1'b1, 1'b1, 1'b0},
    {1'b1, 2'd2, 1'b1, 1'b0, 1'b0},
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b1},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b1},
    {1'b0, 2'd3, 1'b0, 1'b1, 1'b1},
    {1'b1, 2'd3, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_we    = 1'b1;
    bus_addr  = 12'(a);
    bus_wdata = 32'(d);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 12'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic poll_busy(input int dom, output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      rd(OFS_BUSY, v);
      if (v[dom]) n++;
      else break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pwr_ack = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 clk_en", int'(mod_clk_en), 0);
    chk("R1 mod_rst", int'(mod_rst), (1 << NM) - 1);
    chk("R1 pwr_req", int'(pwr_req), 0);
    rd(OFS_MSTAT, v);     chk("R1 mstat0", int'(v), 0);
    rd(OFS_MCTL + 12, v); chk("R1 mctl3", int'(v), 0);
    rd(OFS_DSTAT, v);     chk("R1 dstat0", int'(v), 1);
    rd(OFS_DSTAT + 4, v); chk("R1 dstat1", int'(v), 0);
    rd(OFS_BUSY, v);      chk("R1 busy", int'(v), 0);
    rd(OFS_PEND, v);      chk("R1 pend", int'(v), 0);

    // R2 control word layout
    wr(OFS_MCTL + 4, 'h13F);
    rd(OFS_MCTL + 4, v); chk("R2 mctl readback", int'(v), 'h103);
    rd(OFS_MSTAT + 4, v); chk("R4 no go no change", int'(v), 0);

    // Vector table on domain 0 modules
    foreach (VEC[i]) begin
      int m;
      m = int'(VEC[i][5]);
      wr(OFS_MCTL + 4 * m, (int'(VEC[i][2]) << 8) | int'(VEC[i][4:3]));
      wr(OFS_GO, 1);
      poll_busy(0, n);
      chk("R3 busy length", n, XFER);
      rd(OFS_MSTAT + 4 * m, v);
      chk("R4 status state", int'(v[5:0]), int'(VEC[i][4:3]));
      chk("R5 status clk bit", int'(v[12]), int'(VEC[i][1]));
      chk("R5 clk_en", int'(mod_clk_en[m]), int'(VEC[i][1]));
      chk("R5 mod_rst", int'(mod_rst[m]), int'(VEC[i][0]));
    end

    // R4 request without go leaves module 1 enabled
    wr(OFS_MCTL + 4, 'h101);
    rd(OFS_MSTAT + 4, v); chk("R4 held state", int'(v[5:0]), 3);
    chk("R4 held clk_en", int'(mod_clk_en[1]), 1);
    // R5 local reset takes effect at once
    wr(OFS_MCTL + 4, 'h003);
    chk("R5 lrst immediate", int'(mod_rst[1]), 1);
    chk("R5 lrst keeps clock", int'(mod_clk_en[1]), 1);

    // R8 repeated go ignored
    wr(OFS_GO, 1);
    wr(OFS_GO, 1);
    poll_busy(0, n);
    chk("R8 busy not extended", n, XFER - 1);

    // R6 / R7 power up domain 1
    wr(OFS_MCTL + 8, 'h103);
    wr(OFS_DCTL + 4, 'h001);
    wr(OFS_GO, 2);
    chk("R6 pwr_req raised", int'(pwr_req), 2);
    rd(OFS_PEND, v); chk("R6 pend bit", int'(v), 2);
    repeat (5) @(negedge clk);
    chk("R6 pwr_req held", int'(pwr_req), 2);
    rd(OFS_BUSY, v); chk("R3 other domain idle", int'(v), 2);
    pwr_ack = 2'b10;
    @(negedge clk);
    pwr_ack = '0;
    chk("R6 req dropped on ack", int'(pwr_req), 0);
    repeat (6) @(negedge clk);
    rd(OFS_PEND, v);      chk("R7 pend until good", int'(v), 2);
    rd(OFS_DSTAT + 4, v); chk("R7 still off", int'(v), 0);
    chk("R7 module waits", int'(mod_clk_en[2]), 0);
    wr(OFS_DCTL + 4, 'h101);
    poll_busy(1, n);
    chk("R7 completion time", n, XFER + 1);
    rd(OFS_DSTAT + 4, v); chk("R7 domain on", int'(v), 1);
    rd(OFS_DCTL + 4, v);  chk("R7 good cleared", int'(v), 1);
    rd(OFS_MSTAT + 8, v); chk("R4 domain1 module", int'(v), 'h1003);
    chk("R5 domain1 clk_en", int'(mod_clk_en[2]), 1);

    // R9 power down domain 1
    wr(OFS_DCTL + 4, 0);
    wr(OFS_GO, 2);
    chk("R9 no request", int'(pwr_req), 0);
    poll_busy(1, n);
    chk("R9 busy length", n, XFER);
    rd(OFS_DSTAT + 4, v); chk("R9 domain off", int'(v), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule